// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Event Counter

This block holds two 16-bit counting engines, unit 0 and unit 1. Each has a low byte and a high byte. A processor configures the pair through a small byte-wide register port. For each unit, software picks a counting mode, a count source and an optional hardware gate, and then starts or stops the unit with a run bit. The source is either the machine-cycle strobe, which is one clock in every `MC_DIV` clocks, or falling transitions on an external event pin. When gating is on, the unit counts only while its gate pin is high, so software can measure the width of a pulse.

A unit raises a sticky overflow flag when it wraps. The flag stays set until software clears it. Unit 1 also drives a one-clock overflow strobe for a rate generator that sits outside the block. Four modes are available:
- a 13-bit counter made of a 5-bit prescaler and an 8-bit count;
- a full 16-bit counter;
- an 8-bit counter that reloads itself from the high byte;
- a split mode that exists only on unit 0.

In split mode, unit 0 becomes two independent 8-bit counters, and the upper one takes over unit 1's flag. If unit 1 is put into mode 3 it holds its value.

Top module: `tc_pair`

## Requirements
- R1: After a synchronous reset, all registers read zero, both flags are low and the overflow strobe is low.
- R2: In timer mode, a running unit advances by exactly one for each machine cycle, which is one clock in `MC_DIV`.
- R3: Mode 1 (mode field 01) counts over 16 bits. Stepping from 0xFFFF gives 0x0000 and sets the unit's flag.
- R4: Mode 0 (mode field 00) uses bits 4:0 of the low byte as a prescaler. When the prescaler wraps from 31 it carries into the high byte. Bits 7:5 of the low byte hold their value. The flag is set when the high byte wraps from 0xFF.
- R5: Mode 2 (mode field 10) steps only the low byte. When the low byte steps from 0xFF it loads the high byte's value instead and sets the flag. The high byte is unchanged.
- R6: In mode 3 (mode field 11) on unit 0, the low byte counts under unit 0's controls and sets flag 0. The high byte counts machine cycles while unit 1's run bit is set, and its wrap from 0xFF sets flag 1.
- R7: `t1_ovf_pulse` is high for one clock on every unit 1 overflow. While unit 0 is in mode 3, unit 1 overflows never set flag 1.
- R8: In counter mode, one count is taken for each 1-to-0 change between successive machine-cycle samples of the synchronized event pin.
- R9: With gating enabled, a running unit counts only while its synchronized gate pin is high.
- R10: A processor write to a counter byte takes priority over a step in the same clock, and that step's overflow is dropped.
- R11: A flag stays set once set. In a status write, a 0 in the flag's bit clears the flag and a 1 leaves it alone. An overflow in the same clock wins.
- R12: Addresses 0 to 3 hold unit 0 low/high and unit 1 low/high. Address 4 is config: bits 1:0 mode, 2 counter select, 3 gate enable for unit 0, and bits 7:4 the same fields for unit 1. Address 5 is status: bit 0 run0, bit 1 run1, bit 2 flag0, bit 3 flag1. Reads return data one clock later, and addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one clock after bus_rd |
| ev0_pin | input | 1 | Unit 0 external event input |
| ev1_pin | input | 1 | Unit 1 external event input |
| gate0_pin | input | 1 | Unit 0 gate input |
| gate1_pin | input | 1 | Unit 1 gate input |
| t0_flag | output | 1 | Sticky overflow flag 0 |
| t1_flag | output | 1 | Sticky overflow flag 1 |
| t1_ovf_pulse | output | 1 | One-clock strobe on unit 1 overflow |

## Verification
The bench builds the block with `MC_DIV` set to 4 and `SYNC_STAGES` left at 2. The short machine cycle lets runs of twenty counts, the carry out of the 13-bit prescaler and several event-pin periods all fit in a few hundred clocks. Because the bench starts and stops units a whole number of machine cycles apart, every count it checks is exact. The same parameter values also make the write-versus-step contest happen several times within one burst of writes.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [1:0] {
    M_PRE13 = 2'b00,
    M_FULL16 = 2'b01,
    M_RELOAD8 = 2'b10,
    M_SPLIT = 2'b11
  } tc_mode_e;

  typedef struct packed {
    logic     gate;
    logic     ctr;
    tc_mode_e mode;
  } tc_cfg_t;

  localparam logic [2:0] A_U0LO = 3'd0;
  localparam logic [2:0] A_U0HI = 3'd1;
  localparam logic [2:0] A_U1LO = 3'd2;
  localparam logic [2:0] A_U1HI = 3'd3;
  localparam logic [2:0] A_CFG  = 3'd4;
  localparam logic [2:0] A_STAT = 3'd5;
endpackage

// File: rtl/tc_tick.sv
module tc_tick #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tc_sync.sv
module tc_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] sh [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) sh[i] <= '0;
    end else begin
      sh[0] <= din;
      for (int i = 1; i < STAGES; i++) sh[i] <= sh[i-1];
    end
  end

  assign dout = sh[STAGES-1];
endmodule

// File: rtl/tc_unit.sv
module tc_unit
  import tc_pkg::*;
#(
  parameter bit SPLIT_OK = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  tc_cfg_t    cfg,
  input  logic       run,
  input  logic       run_hi,
  input  logic       gate_lvl,
  input  logic       ext_fall,
  input  logic       tick,
  input  logic       wr_lo,
  input  logic       wr_hi,
  input  logic [7:0] wdata,
  output logic [7:0] lo,
  output logic [7:0] hi,
  output logic       ovf,
  output logic       ovf_hi
);
  logic       step;
  logic       wr_any;
  logic [7:0] nlo, nhi;

  assign step   = run && (!cfg.gate || gate_lvl) && (cfg.ctr ? ext_fall : tick);
  assign wr_any = wr_lo || wr_hi;

  always_comb begin
    nlo    = lo;
    nhi    = hi;
    ovf    = 1'b0;
    ovf_hi = 1'b0;
    case (cfg.mode)
      M_PRE13: if (step && !wr_any) begin
        nlo = {lo[7:5], lo[4:0] + 5'd1};
        if (lo[4:0] == 5'h1F) begin
          nhi = hi + 8'd1;
          ovf = (hi == 8'hFF);
        end
      end
      M_FULL16: if (step && !wr_any) begin
        {nhi, nlo} = {hi, lo} + 16'd1;
        ovf = ({hi, lo} == 16'hFFFF);
      end
      M_RELOAD8: if (step && !wr_any) begin
        if (lo == 8'hFF) begin
          nlo = hi;
          ovf = 1'b1;
        end else begin
          nlo = lo + 8'd1;
        end
      end
      M_SPLIT: if (SPLIT_OK) begin
        if (step && !wr_lo) begin
          nlo = lo + 8'd1;
          ovf = (lo == 8'hFF);
        end
        if (run_hi && tick && !wr_hi) begin
          nhi    = hi + 8'd1;
          ovf_hi = (hi == 8'hFF);
        end
      end
      default: ;
    endcase
    if (wr_lo) nlo = wdata;
    if (wr_hi) nhi = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= nlo;
      hi <= nhi;
    end
  end
endmodule

// File: rtl/tc_pair.sv
module tc_pair
  import tc_pkg::*;
#(
  parameter int MC_DIV      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       ev0_pin,
  input  logic       ev1_pin,
  input  logic       gate0_pin,
  input  logic       gate1_pin,
  output logic       t0_flag,
  output logic       t1_flag,
  output logic       t1_ovf_pulse
);
  localparam int NU = 2;

  logic          mc_tick;
  logic [2*NU-1:0] pins_s;
  logic [NU-1:0] ev_s, gate_s, ev_prev, ev_fall;
  tc_cfg_t       cfg [NU];
  logic [NU-1:0] run;
  logic [7:0]    u_lo [NU];
  logic [7:0]    u_hi [NU];
  logic [NU-1:0] u_ovf, u_ovf_hi;
  logic [7:0]    t0_lo;
  logic          split0, set0, set1, stat_wr;

  tc_tick #(.DIV(MC_DIV)) u_tick (.clk(clk), .rst(rst), .tick(mc_tick));

  tc_sync #(.W(2*NU), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .din({gate1_pin, gate0_pin, ev1_pin, ev0_pin}),
    .dout(pins_s)
  );
  assign ev_s   = pins_s[NU-1:0];
  assign gate_s = pins_s[2*NU-1:NU];

  always_ff @(posedge clk) begin
    if (rst) ev_prev <= '0;
    else if (mc_tick) ev_prev <= ev_s;
  end
  assign ev_fall = {NU{mc_tick}} & ev_prev & ~ev_s;

  for (genvar g = 0; g < NU; g++) begin : g_unit
    tc_unit #(.SPLIT_OK(g == 0)) u_unit (
      .clk(clk), .rst(rst), .cfg(cfg[g]), .run(run[g]), .run_hi(run[NU-1]),
      .gate_lvl(gate_s[g]), .ext_fall(ev_fall[g]), .tick(mc_tick),
      .wr_lo(bus_wr && bus_addr == 3'(2*g)),
      .wr_hi(bus_wr && bus_addr == 3'(2*g+1)),
      .wdata(bus_wdata), .lo(u_lo[g]), .hi(u_hi[g]),
      .ovf(u_ovf[g]), .ovf_hi(u_ovf_hi[g])
    );
  end

  assign t0_lo   = u_lo[0];
  assign split0  = (cfg[0].mode == M_SPLIT);
  assign set0    = u_ovf[0];
  assign set1    = split0 ? u_ovf_hi[0] : (u_ovf[1] || u_ovf_hi[1]);
  assign stat_wr = bus_wr && (bus_addr == A_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg[0]       <= '0;
      cfg[1]       <= '0;
      run          <= '0;
      t0_flag      <= 1'b0;
      t1_flag      <= 1'b0;
      t1_ovf_pulse <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_CFG) begin
        cfg[0] <= tc_cfg_t'(bus_wdata[3:0]);
        cfg[1] <= tc_cfg_t'(bus_wdata[7:4]);
      end
      if (stat_wr) run <= bus_wdata[1:0];
      t0_flag      <= (t0_flag && !(stat_wr && !bus_wdata[2])) || set0;
      t1_flag      <= (t1_flag && !(stat_wr && !bus_wdata[3])) || set1;
      t1_ovf_pulse <= u_ovf[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !bus_rd) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        A_U0LO:  bus_rdata <= u_lo[0];
        A_U0HI:  bus_rdata <= u_hi[0];
        A_U1LO:  bus_rdata <= u_lo[1];
        A_U1HI:  bus_rdata <= u_hi[1];
        A_CFG:   bus_rdata <= {cfg[1], cfg[0]};
        A_STAT:  bus_rdata <= {4'b0, t1_flag, t0_flag, run};
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tc_pair_chk.sv
module tc_pair_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [2:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       t0_flag,
  input logic       t1_flag,
  input logic       t1_ovf_pulse,
  input logic       mc_tick,
  input logic [7:0] t0_lo
);
  // R1: reset leaves outputs quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!t0_flag && !t1_flag && !t1_ovf_pulse && bus_rdata == 8'h00));

  // R2: machine-cycle strobe never lasts two clocks
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (rst)
    mc_tick |=> !mc_tick);

  // R7: overflow strobe is one clock wide
  a_r7_pulse_lone: assert property (@(posedge clk) disable iff (rst)
    t1_ovf_pulse |=> !t1_ovf_pulse);

  // R10: a written low byte holds the written value next clock
  a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 3'd0) |=> (t0_lo == $past(bus_wdata)));

  // R11: flag persists unless status is written
  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (t0_flag && !(bus_wr && bus_addr == 3'd5)) |=> t0_flag);

  // R12: unmapped addresses read zero
  a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr > 3'd5) |=> (bus_rdata == 8'h00));
endmodule

bind tc_pair tc_pair_chk u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .t0_flag(t0_flag), .t1_flag(t1_flag), .t1_ovf_pulse(t1_ovf_pulse),
  .mc_tick(mc_tick), .t0_lo(t0_lo)
);

// File: tb/tc_pair_tb_top.sv
module tc_pair_tb_top;
  localparam int MC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic ev0_pin = 1'b0, ev1_pin = 1'b0, gate0_pin = 1'b0, gate1_pin = 1'b0;
  logic t0_flag, t1_flag, t1_ovf_pulse;

  int checks = 0;
  int errors = 0;
  int pulse_cnt = 0;

  always #10 clk = ~clk;

  tc_pair #(.MC_DIV(MC), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev0_pin(ev0_pin), .ev1_pin(ev1_pin), .gate0_pin(gate0_pin),
    .gate1_pin(gate1_pin), .t0_flag(t0_flag), .t1_flag(t1_flag),
    .t1_ovf_pulse(t1_ovf_pulse)
  );

  always @(negedge clk) if (!rst && t1_ovf_pulse) pulse_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // run the selected units for exactly n machine cycles, keeping flags
  task automatic run_ticks(input logic [1:0] runs, input int n);
    wr(3'd5, {4'b0011, 2'b00, runs} | 8'h0C);
    repeat (n * MC - 1) @(negedge clk);
    wr(3'd5, 8'h0C);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk($sformatf("R1 reg %0d after reset", a), d, 0);
    end
    chk("R1 flags after reset", {t1_flag, t0_flag, t1_ovf_pulse}, 0);
  endtask

  task automatic t_full16;
    logic [7:0] l, h;
    wr(3'd4, 8'h11);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    run_ticks(2'b01, 7);
    rd(3'd0, l);
    chk("R2 seven machine cycles", l, 8'h07);
    wr(3'd0, 8'hF0); wr(3'd1, 8'hFF);
    run_ticks(2'b01, 20);
    rd(3'd0, l); rd(3'd1, h);
    chk("R3 16-bit wrap value", {h, l}, 16'h0004);
    chk("R3 flag0 on wrap", t0_flag, 1);
    chk("R11 flag kept by status write of 1", t0_flag, 1);
    wr(3'd5, 8'h08);
    chk("R11 flag0 cleared by write of 0", t0_flag, 0);
  endtask

  task automatic t_pre13;
    logic [7:0] l, h;
    wr(3'd4, 8'h10);
    wr(3'd0, 8'hFE); wr(3'd1, 8'h12);
    run_ticks(2'b01, 3);
    rd(3'd0, l); rd(3'd1, h);
    chk("R4 prescaler carry and bits 7:5 held", {h, l}, 16'h13E1);
    chk("R4 no flag without high-byte wrap", t0_flag, 0);
    wr(3'd0, 8'h1F); wr(3'd1, 8'hFF);
    run_ticks(2'b01, 1);
    rd(3'd0, l); rd(3'd1, h);
    chk("R4 13-bit wrap value", {h, l}, 16'h0000);
    chk("R4 flag0 on 13-bit wrap", t0_flag, 1);
    wr(3'd5, 8'h08);
  endtask

  task automatic t_reload8;
    logic [7:0] l, h;
    wr(3'd4, 8'h12);
    wr(3'd1, 8'hF0); wr(3'd0, 8'hFD);
    run_ticks(2'b01, 5);
    rd(3'd0, l); rd(3'd1, h);
    chk("R5 low byte after reload", l, 8'hF2);
    chk("R5 high byte unchanged", h, 8'hF0);
    chk("R5 flag0 on reload", t0_flag, 1);
    wr(3'd5, 8'h00);
  endtask

  task automatic t_split;
    logic [7:0] l, h;
    wr(3'd4, 8'h13);
    wr(3'd0, 8'hFE); wr(3'd1, 8'hFE);
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
    pulse_cnt = 0;
    run_ticks(2'b01, 3);
    rd(3'd0, l); rd(3'd1, h);
    chk("R6 split low byte", l, 8'h01);
    chk("R6 split high byte idle without run1", h, 8'hFE);
    chk("R6 split flags after low wrap", {t1_flag, t0_flag}, 2'b01);
    wr(3'd5, 8'h00);
    run_ticks(2'b10, 3);
    rd(3'd1, h);
    chk("R6 split high byte under run1", h, 8'h01);
    chk("R6 high-byte wrap sets flag1", t1_flag, 1);
    rd(3'd2, l); rd(3'd3, h);
    chk("R7 unit1 keeps counting in split", {h, l}, 16'h0001);
    chk("R7 strobe on unit1 wrap", pulse_cnt, 1);
    wr(3'd5, 8'h00);
    wr(3'd1, 8'h10); wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
    run_ticks(2'b10, 3);
    chk("R7 unit1 wrap gives no flag1 in split", t1_flag, 0);
    chk("R7 strobe still produced", pulse_cnt, 2);
    wr(3'd4, 8'h11);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    run_ticks(2'b10, 1);
    chk("R7 unit1 wrap sets flag1 normally", t1_flag, 1);
    chk("R7 strobe count", pulse_cnt, 3);
    wr(3'd5, 8'h00);
  endtask

  task automatic t_events;
    logic [7:0] l;
    wr(3'd4, 8'h51);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd5, 8'h0E);
    for (int k = 0; k < 5; k++) begin
      ev1_pin = 1'b1;
      repeat (2 * MC) @(negedge clk);
      ev1_pin = 1'b0;
      repeat (2 * MC) @(negedge clk);
    end
    repeat (4 * MC) @(negedge clk);
    wr(3'd5, 8'h0C);
    rd(3'd2, l);
    chk("R8 five falling events counted", l, 8'h05);
  endtask

  task automatic t_gate;
    logic [7:0] l;
    wr(3'd4, 8'h19);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    gate0_pin = 1'b0;
    repeat (4) @(negedge clk);
    run_ticks(2'b01, 10);
    rd(3'd0, l);
    chk("R9 no count with gate low", l, 8'h00);
    gate0_pin = 1'b1;
    repeat (6) @(negedge clk);
    run_ticks(2'b01, 10);
    rd(3'd0, l);
    chk("R9 count with gate high", l, 8'h0A);
  endtask

  task automatic t_wr_prio;
    int bad = 0;
    wr(3'd4, 8'h11);
    wr(3'd1, 8'hFF); wr(3'd0, 8'hFF);
    wr(3'd5, 8'h00);
    wr(3'd5, 8'h0D);
    for (int k = 0; k < 3 * MC; k++) begin
      wr(3'd0, 8'hFF);
      if (t0_flag) bad++;
    end
    chk("R10 write beats step, no overflow", bad, 0);
    wr(3'd5, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr(3'd4, 8'h5A);
    rd(3'd4, d);
    chk("R12 config readback", d, 8'h5A);
    wr(3'd5, 8'h03);
    rd(3'd5, d);
    chk("R12 status run bits", d, 8'h03);
    wr(3'd5, 8'h00);
    rd(3'd6, d);
    chk("R12 unmapped reads zero", d, 8'h00);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full16();
    t_pre13();
    t_reload8();
    t_split();
    t_events();
    t_gate();
    t_wr_prio();
    t_regs();
    finish_run();
  end
endmodule